// File: doc/BRIEF.md
# Tag-Line Vector Update and Upward Contraction Engine

This engine sits behind the level-1 tag cache of a tagged-memory system. Each time a modified 64-byte tag line is evicted, the engine receives the line together with the address of the fourth-level entry that owns it and the addresses of the three entries above it on the walk path. It reads that owning entry and its 64-bit line-summary vector. It decides from the evicted line alone whether the line is uniform and equal to the entry's inline tag, and writes the vector back with that one bit updated.

When that update turns the summary bit from 0 to 1, the whole vector is then all ones and the entry still points at a leaf subtable, the leaf can be released. The engine nulls the pointer, keeps the inline tag, and hands the 4 KB leaf chunk to a free port. It then walks upward. At each level it reads the subtable that holds the entry just rewritten, from first entry to last, and gives up on the first entry that has a pointer or a tag different from entry 0. A complete uniform scan nulls the parent entry, stores the common tag in it and frees the scanned chunk. The root-level subtable is never scanned.

All three data paths use valid/ready. Write-backs are accepted only while `wb_ready` is high, which is exactly while the engine is idle. A memory request or a free offer, once raised, holds its address and data until accepted. Read data returns on `mem_rsp_valid` some cycles after the read request is accepted, and the engine waits for it.

Top module: `tlc_engine`

## Requirements
- R1: A raised `mem_req_valid` or `free_valid` keeps its request fields unchanged until the matching ready is seen; after reset, `wb_ready` is 1 and `busy`, `mem_req_valid` and `free_valid` are 0.
- R2: The summary bit for the evicted line is written as 1 when every tag in the line equals tag 0 of the line and that value, zero-extended to 12 bits, equals entry bits 11:0. `wb_mode` 0 means 1-bit tags, 1 means 2-bit tags and 2 means 4-bit tags; tag k occupies line bits [k*w +: w].
- R3: In every other case the summary bit is written as 0, including `wb_mode` 3 and an inline tag whose bits above the tag width are nonzero; all other vector bits are written back unchanged.
- R4: A fourth-level entry at address A holds its pointer in bits 63:12 (null when all zero) and its inline tag in bits 11:0. Its summary vector is the 64-bit word at A+8, and bit i covers line index `wb_idx` = i.
- R5: Leaf contraction occurs when the bit goes from 0 to 1, the new vector is all ones and the pointer is non-null. The entry is rewritten with a null pointer and the same tag, and the leaf chunk (address bits above 11, zero below) is offered on the free port.
- R6: If the bit was already 1, the vector is not all ones, or the pointer is null, the vector write is the only effect.
- R7: After a contraction, the subtable holding the rewritten entry is scanned: 256 entries at 16-byte stride for level 4, and 512 entries at 8-byte stride for levels 3 and 2. A uniform scan writes the parent entry on the path as {null, common tag}, frees the scanned chunk, and continues with the parent's subtable. It stops after the level-2 subtable.
- R8: A scan aborts at the first entry with a non-null pointer or with a tag that differs from entry 0's tag, and issues no further write or free.
- R9: `busy` is high from the cycle after a write-back is accepted until the engine returns to idle, and `wb_ready` is low whenever `busy` is high.
- R10: Effects occur in this order: vector write, entry write, leaf free, then for each level the parent write followed by that chunk's free. Memory requests and free offers are never raised together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wb_valid | input | 1 | Write-back offered |
| wb_ready | output | 1 | Write-back accepted this cycle if valid |
| wb_line | input | LINE_W (512) | Evicted tag line |
| wb_mode | input | 2 | Tag width code: 0=1 bit, 1=2 bits, 2=4 bits, 3 unsupported |
| wb_idx | input | 6 | Line index within the leaf subtable |
| wb_ette_addr | input | AW (40) | Address of the owning fourth-level entry |
| wb_path | input | 3*AW | Entry addresses on the walk path; slot k holds the level k+1 entry |
| busy | output | 1 | Engine is processing a write-back |
| mem_req_valid | output | 1 | Memory request offered |
| mem_req_ready | input | 1 | Memory request accepted |
| mem_req_we | output | 1 | 1 = write, 0 = read |
| mem_req_addr | output | AW | Byte address of the 64-bit word |
| mem_req_wdata | output | 64 | Write data |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 64 | Read data |
| free_valid | output | 1 | Chunk release offered |
| free_ready | input | 1 | Chunk release accepted |
| free_addr | output | AW | 4 KB-aligned chunk address |

## Verification
On every cycle the assertions check the port-level rules: held requests stay stable under back-pressure, a freed chunk is non-null and 4 KB aligned, memory and free offers never overlap, and the engine is busy and refuses write-backs after an accept. Whether each summary bit, entry rewrite and free matches the tag rules can only be shown by the bench scenarios. A reference model predicts the exact sequence of writes and frees for each eviction. The scenarios cover all three tag widths and the unsupported code, an already-set bit, a null leaf pointer, a scan that aborts on a differing tag, one that aborts on a live pointer, and a full three-level collapse.

// File: rtl/tlc_pkg.sv
package tlc_pkg;
  localparam int ENTRY_W  = 64;
  localparam int CHUNK_LG = 12;
  localparam int TAGF_W   = 12;
  localparam int IDX_W    = CHUNK_LG - 3;
  localparam logic [2:0] LVL_LEAFPAR = 3'd4;
  localparam logic [2:0] LVL_LAST    = 3'd2;

  typedef enum logic [3:0] {
    ST_IDLE, ST_RD_ENT, ST_WT_ENT, ST_RD_VEC, ST_WT_VEC, ST_WR_VEC,
    ST_WR_ENT, ST_FREE, ST_SCAN_RD, ST_SCAN_WT, ST_WR_PAR
  } tlc_state_e;
endpackage

// File: rtl/tlc_line_judge.sv
// Decides whether an evicted line is uniform and equal to the inline tag.
module tlc_line_judge #(
  parameter int LINE_W = 512,
  parameter int TAGF_W = 12
) (
  input  logic [LINE_W-1:0] line,
  input  logic [1:0]        mode,
  input  logic [TAGF_W-1:0] tag_field,
  output logic              match
);
  logic [3:0] uni;
  logic [3:0] eq;

  for (genvar k = 0; k < 3; k++) begin : g_width
    localparam int W = 1 << k;
    assign uni[k] = (line == {(LINE_W / W){line[W-1:0]}});
    assign eq[k]  = (tag_field == TAGF_W'(line[W-1:0]));
  end
  assign uni[3] = 1'b0;
  assign eq[3]  = 1'b0;

  assign match = uni[mode] & eq[mode];
endmodule

// File: rtl/tlc_entry_split.sv
// Field view of a table entry word.
module tlc_entry_split #(
  parameter int AW = 40
) (
  input  logic [tlc_pkg::ENTRY_W-1:0] word,
  output logic                        is_null,
  output logic [tlc_pkg::TAGF_W-1:0]  tag,
  output logic [AW-1:0]               chunk
);
  import tlc_pkg::*;
  assign is_null = (word[ENTRY_W-1:CHUNK_LG] == '0);
  assign tag     = word[TAGF_W-1:0];
  assign chunk   = {word[AW-1:CHUNK_LG], {CHUNK_LG{1'b0}}};
endmodule

// File: rtl/tlc_scan_idx.sv
// Entry index and byte offset inside a 4 KB subtable during a scan.
module tlc_scan_idx (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         clear,
  input  logic                         step,
  input  logic                         wide,
  output logic [tlc_pkg::IDX_W-1:0]    idx,
  output logic [tlc_pkg::CHUNK_LG-1:0] offset,
  output logic                         last
);
  import tlc_pkg::*;
  localparam logic [IDX_W-1:0] LAST_NARROW = '1;
  localparam logic [IDX_W-1:0] LAST_WIDE   = {1'b0, {(IDX_W-1){1'b1}}};

  always_ff @(posedge clk) begin
    if (!rst_n)     idx <= '0;
    else if (clear) idx <= '0;
    else if (step)  idx <= idx + 1'b1;
  end

  assign offset = wide ? {idx[IDX_W-2:0], 4'b0000} : {idx, 3'b000};
  assign last   = wide ? (idx == LAST_WIDE) : (idx == LAST_NARROW);
endmodule

// File: rtl/tlc_engine.sv
module tlc_engine #(
  parameter int AW     = 40,
  parameter int LINE_W = 512
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wb_valid,
  output logic              wb_ready,
  input  logic [LINE_W-1:0] wb_line,
  input  logic [1:0]        wb_mode,
  input  logic [5:0]        wb_idx,
  input  logic [AW-1:0]     wb_ette_addr,
  input  logic [3*AW-1:0]   wb_path,
  output logic              busy,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_req_we,
  output logic [AW-1:0]     mem_req_addr,
  output logic [63:0]       mem_req_wdata,
  input  logic              mem_rsp_valid,
  input  logic [63:0]       mem_rsp_data,
  output logic              free_valid,
  input  logic              free_ready,
  output logic [AW-1:0]     free_addr
);
  import tlc_pkg::*;

  localparam logic [AW-1:0] VEC_OFS = AW'(8);

  tlc_state_e          st;
  logic [LINE_W-1:0]   line_q;
  logic [1:0]          mode_q;
  logic [5:0]          idx_q;
  logic [AW-1:0]       ette_q;
  logic [3*AW-1:0]     path_q;
  logic [ENTRY_W-1:0]  ent_q;
  logic [63:0]         vec_q;
  logic [2:0]          lvl_q;
  logic [AW-1:0]       base_q;
  logic [AW-1:0]       chunk_q;
  logic [TAGF_W-1:0]   common_q;
  logic                go_scan_q;

  // owning entry fields
  logic                ent_null;
  logic [TAGF_W-1:0]   ent_tag;
  logic [AW-1:0]       ent_chunk;

  tlc_entry_split #(.AW(AW)) u_ent (
    .word(ent_q), .is_null(ent_null), .tag(ent_tag), .chunk(ent_chunk)
  );

  logic line_match;
  tlc_line_judge #(.LINE_W(LINE_W), .TAGF_W(TAGF_W)) u_judge (
    .line(line_q), .mode(mode_q), .tag_field(ent_tag), .match(line_match)
  );

  logic [63:0] vec_new;
  always_comb begin
    vec_new = vec_q;
    vec_new[idx_q] = line_match;
  end

  logic leaf_go;
  assign leaf_go = line_match & ~vec_q[idx_q] & (&vec_new) & ~ent_null;

  // scan position
  logic [IDX_W-1:0]    sc_idx;
  logic [CHUNK_LG-1:0] sc_ofs;
  logic                sc_last;
  logic                sc_clear;
  logic                sc_step;
  logic                sc_wide;
  logic                rsp_null;
  logic [TAGF_W-1:0]   rsp_tag;
  logic                sc_bad;

  assign sc_wide  = (lvl_q == LVL_LEAFPAR);
  assign rsp_null = (mem_rsp_data[ENTRY_W-1:CHUNK_LG] == '0);
  assign rsp_tag  = mem_rsp_data[TAGF_W-1:0];
  assign sc_bad   = ~rsp_null | ((sc_idx != '0) & (rsp_tag != common_q));
  assign sc_clear = (st == ST_FREE) & free_ready;
  assign sc_step  = (st == ST_SCAN_WT) & mem_rsp_valid & ~sc_bad & ~sc_last;

  tlc_scan_idx u_scan (
    .clk(clk), .rst_n(rst_n), .clear(sc_clear), .step(sc_step), .wide(sc_wide),
    .idx(sc_idx), .offset(sc_ofs), .last(sc_last)
  );

  // path entry one level above the subtable under scan
  logic [AW-1:0] parent_addr;
  always_comb begin
    case (lvl_q)
      3'd4:    parent_addr = wb_path_slot(path_q, 2);
      3'd3:    parent_addr = wb_path_slot(path_q, 1);
      default: parent_addr = wb_path_slot(path_q, 0);
    endcase
  end

  function automatic logic [AW-1:0] wb_path_slot(input logic [3*AW-1:0] p, input int s);
    return p[s*AW +: AW];
  endfunction

  function automatic logic [AW-1:0] chunk_of(input logic [AW-1:0] a);
    return {a[AW-1:CHUNK_LG], {CHUNK_LG{1'b0}}};
  endfunction

  // request outputs
  always_comb begin
    mem_req_valid = 1'b0;
    mem_req_we    = 1'b0;
    mem_req_addr  = '0;
    mem_req_wdata = '0;
    case (st)
      ST_RD_ENT:  begin mem_req_valid = 1'b1; mem_req_addr = ette_q; end
      ST_RD_VEC:  begin mem_req_valid = 1'b1; mem_req_addr = ette_q + VEC_OFS; end
      ST_WR_VEC:  begin
        mem_req_valid = 1'b1; mem_req_we = 1'b1;
        mem_req_addr  = ette_q + VEC_OFS; mem_req_wdata = vec_new;
      end
      ST_WR_ENT:  begin
        mem_req_valid = 1'b1; mem_req_we = 1'b1;
        mem_req_addr  = ette_q; mem_req_wdata = ENTRY_W'(ent_tag);
      end
      ST_SCAN_RD: begin mem_req_valid = 1'b1; mem_req_addr = base_q + AW'(sc_ofs); end
      ST_WR_PAR:  begin
        mem_req_valid = 1'b1; mem_req_we = 1'b1;
        mem_req_addr  = parent_addr; mem_req_wdata = ENTRY_W'(common_q);
      end
      default: ;
    endcase
  end

  assign free_valid = (st == ST_FREE);
  assign free_addr  = chunk_q;
  assign wb_ready   = (st == ST_IDLE);
  assign busy       = (st != ST_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      line_q    <= '0;
      mode_q    <= '0;
      idx_q     <= '0;
      ette_q    <= '0;
      path_q    <= '0;
      ent_q     <= '0;
      vec_q     <= '0;
      lvl_q     <= '0;
      base_q    <= '0;
      chunk_q   <= '0;
      common_q  <= '0;
      go_scan_q <= 1'b0;
    end else begin
      case (st)
        ST_IDLE: if (wb_valid) begin
          line_q <= wb_line;
          mode_q <= wb_mode;
          idx_q  <= wb_idx;
          ette_q <= wb_ette_addr;
          path_q <= wb_path;
          st     <= ST_RD_ENT;
        end
        ST_RD_ENT: if (mem_req_ready) st <= ST_WT_ENT;
        ST_WT_ENT: if (mem_rsp_valid) begin
          ent_q <= mem_rsp_data;
          st    <= ST_RD_VEC;
        end
        ST_RD_VEC: if (mem_req_ready) st <= ST_WT_VEC;
        ST_WT_VEC: if (mem_rsp_valid) begin
          vec_q <= mem_rsp_data;
          st    <= ST_WR_VEC;
        end
        ST_WR_VEC: if (mem_req_ready) st <= leaf_go ? ST_WR_ENT : ST_IDLE;
        ST_WR_ENT: if (mem_req_ready) begin
          chunk_q   <= ent_chunk;
          go_scan_q <= 1'b1;
          lvl_q     <= LVL_LEAFPAR;
          base_q    <= chunk_of(ette_q);
          st        <= ST_FREE;
        end
        ST_FREE: if (free_ready) st <= go_scan_q ? ST_SCAN_RD : ST_IDLE;
        ST_SCAN_RD: if (mem_req_ready) st <= ST_SCAN_WT;
        ST_SCAN_WT: if (mem_rsp_valid) begin
          if (sc_idx == '0) common_q <= rsp_tag;
          if (sc_bad)       st <= ST_IDLE;
          else if (sc_last) st <= ST_WR_PAR;
          else              st <= ST_SCAN_RD;
        end
        ST_WR_PAR: if (mem_req_ready) begin
          chunk_q <= base_q;
          if (lvl_q == LVL_LAST) begin
            go_scan_q <= 1'b0;
          end else begin
            go_scan_q <= 1'b1;
            lvl_q     <= lvl_q - 3'd1;
            base_q    <= chunk_of(parent_addr);
          end
          st <= ST_FREE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/tlc_checker.sv
module tlc_checker #(
  parameter int AW = 40
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wb_valid,
  input logic          wb_ready,
  input logic          busy,
  input logic          mem_req_valid,
  input logic          mem_req_ready,
  input logic          mem_req_we,
  input logic [AW-1:0] mem_req_addr,
  input logic [63:0]   mem_req_wdata,
  input logic          free_valid,
  input logic          free_ready,
  input logic [AW-1:0] free_addr
);
  a_r1_mem_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_we)
      && $stable(mem_req_addr) && $stable(mem_req_wdata));

  a_r1_free_hold: assert property (@(posedge clk) disable iff (!rst_n)
    free_valid && !free_ready |=> free_valid && $stable(free_addr));

  a_r5_free_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    free_valid |-> (free_addr[11:0] == 12'h000) && (free_addr != '0));

  a_r10_one_offer: assert property (@(posedge clk) disable iff (!rst_n)
    !(free_valid && mem_req_valid));

  a_r9_busy_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !wb_ready);

  a_r9_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid && wb_ready |=> busy);
endmodule

bind tlc_engine tlc_checker #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wb_valid(wb_valid), .wb_ready(wb_ready), .busy(busy),
  .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_we(mem_req_we),
  .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
  .free_valid(free_valid), .free_ready(free_ready), .free_addr(free_addr)
);

// File: tb/tb_tlc_engine.sv
module tb_tlc_engine;
  localparam int AW = 40;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic            rst_n = 1'b0;
  logic            wb_valid = 1'b0;
  logic            wb_ready;
  logic [511:0]    wb_line = '0;
  logic [1:0]      wb_mode = '0;
  logic [5:0]      wb_idx = '0;
  logic [AW-1:0]   wb_ette_addr = '0;
  logic [3*AW-1:0] wb_path = '0;
  logic            busy;
  logic            mem_req_valid, mem_req_we;
  logic            mem_req_ready = 1'b0;
  logic [AW-1:0]   mem_req_addr;
  logic [63:0]     mem_req_wdata;
  logic            mem_rsp_valid = 1'b0;
  logic [63:0]     mem_rsp_data = '0;
  logic            free_valid;
  logic            free_ready = 1'b0;
  logic [AW-1:0]   free_addr;

  tlc_engine #(.AW(AW)) dut (.*);

  typedef struct {
    bit            is_free;
    logic [AW-1:0] addr;
    logic [63:0]   data;
    string         req;
  } ev_t;

  ev_t evq[$];
  logic [63:0] mem[logic [AW-1:0]];
  logic [63:0] shadow[logic [AW-1:0]];
  int n_tests = 0;
  int n_fail  = 0;
  int cyc     = 0;

  function automatic logic [63:0] mrd(input logic [AW-1:0] a);
    return mem.exists(a) ? mem[a] : 64'h0;
  endfunction
  function automatic logic [63:0] srd(input logic [AW-1:0] a);
    return shadow.exists(a) ? shadow[a] : 64'h0;
  endfunction
  function automatic logic [63:0] ent(input logic [AW-1:0] ptr, input logic [11:0] tag);
    return 64'(ptr) | 64'(tag);
  endfunction

  task automatic chk(input bit ok, input string r, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", r, act, exp);
    end
  endtask

  task automatic push_ev(input bit f, input logic [AW-1:0] a, input logic [63:0] d, input string r);
    ev_t e;
    e.is_free = f; e.addr = a; e.data = d; e.req = r;
    evq.push_back(e);
    if (!f) shadow[a] = d;
  endtask

  // Behavioural expectation of all writes and frees for one write-back.
  task automatic model_wb(input logic [511:0] line, input logic [1:0] mode, input int idx,
                          input logic [AW-1:0] ette, input logic [3*AW-1:0] path);
    logic [63:0] e, v, nv, x;
    logic [11:0] val, common;
    logic [AW-1:0] base, parent;
    int w, lvl, stride;
    bit uni, match, ok;
    shadow = mem;
    e = srd(ette);
    v = srd(ette + 40'd8);
    w = 1 << mode;
    uni = 1'b1;
    for (int b = 0; b < 512; b++) if (line[b] != line[b % w]) uni = 1'b0;
    val = '0;
    for (int b = 0; b < w; b++) val[b] = line[b];
    match = (mode != 2'd3) && uni && (e[11:0] == val);
    nv = v;
    nv[idx] = match;
    push_ev(1'b0, ette + 40'd8, nv, match ? "R2" : "R3");
    if (match && !v[idx] && (nv == '1) && (e[63:12] != '0)) begin
      push_ev(1'b0, ette, {52'b0, e[11:0]}, "R5");
      push_ev(1'b1, {e[AW-1:12], 12'h000}, '0, "R5");
      lvl = 4;
      base = {ette[AW-1:12], 12'h000};
      while (1) begin
        stride = (lvl == 4) ? 16 : 8;
        common = srd(base)[11:0];
        ok = 1'b1;
        for (int i = 0; i < 4096 / stride; i++) begin
          x = srd(base + AW'(i * stride));
          if (x[63:12] != '0 || x[11:0] != common) begin ok = 1'b0; break; end
        end
        if (!ok) break;
        parent = path[(lvl - 2) * AW +: AW];
        push_ev(1'b0, parent, {52'b0, common}, "R7");
        push_ev(1'b1, base, '0, "R7");
        if (lvl == 2) break;
        lvl--;
        base = {parent[AW-1:12], 12'h000};
      end
    end
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
  endtask

  // Memory and free-port responder; compares every handshake with the model.
  initial begin
    bit rd_pend = 1'b0;
    logic [63:0] rd_dat = '0;
    bit mrdy, frdy;
    ev_t ev;
    forever begin
      @(negedge clk);
      #1;
      cyc++;
      if (cyc > 150000) begin
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
        summary();
        $finish;
      end
      mem_rsp_valid = rd_pend;
      mem_rsp_data  = rd_dat;
      rd_pend = 1'b0;
      if (rst_n && evq.size() != 0)
        chk(busy && !wb_ready, "R9 busy while work pending", {62'b0, busy, wb_ready}, 64'h2);
      mrdy = (cyc % 7) != 2;
      frdy = (cyc % 3) != 0;
      mem_req_ready = mrdy;
      free_ready    = frdy;
      if (rst_n && mem_req_valid && mrdy) begin
        if (mem_req_we) begin
          if (evq.size() == 0 || evq[0].is_free) begin
            chk(1'b0, "R10 unexpected write", 64'(mem_req_addr), 64'h0);
          end else begin
            ev = evq.pop_front();
            chk(mem_req_addr == ev.addr && mem_req_wdata == ev.data, {ev.req, "/R10 write"},
                mem_req_wdata ^ 64'(mem_req_addr), ev.data ^ 64'(ev.addr));
          end
          mem[mem_req_addr] = mem_req_wdata;
        end else begin
          rd_pend = 1'b1;
          rd_dat  = mrd(mem_req_addr);
        end
      end
      if (rst_n && free_valid && frdy) begin
        if (evq.size() == 0 || !evq[0].is_free) begin
          chk(1'b0, "R10 unexpected free", 64'(free_addr), 64'h0);
        end else begin
          ev = evq.pop_front();
          chk(free_addr == ev.addr, {ev.req, "/R10 free"}, 64'(free_addr), 64'(ev.addr));
        end
      end
    end
  end

  task automatic do_wb(input logic [511:0] line, input logic [1:0] mode, input int idx,
                       input logic [AW-1:0] ette, input logic [3*AW-1:0] path);
    @(negedge clk);
    wb_line = line; wb_mode = mode; wb_idx = 6'(idx);
    wb_ette_addr = ette; wb_path = path; wb_valid = 1'b1;
    while (!wb_ready) @(negedge clk);
    @(posedge clk);
    #1;
    model_wb(line, mode, idx, ette, path);
    wb_valid = 1'b0;
    @(negedge clk);
    while (busy) @(negedge clk);
    repeat (2) @(negedge clk);
    chk(evq.size() == 0, "R6/R8 no missing effects", 64'(evq.size()), 64'h0);
    evq.delete();
  endtask

  localparam logic [511:0] ONES  = '1;
  localparam logic [511:0] ZEROS = '0;
  localparam logic [511:0] MIXED = {{511{1'b1}}, 1'b0};
  localparam logic [511:0] PAT2  = {256{2'b10}};
  localparam logic [511:0] PAT4  = {128{4'hA}};

  initial begin
    logic [3*AW-1:0] pa, pb, pc;
    pa = {40'h13018, 40'h12010, 40'h11008};
    pb = {40'h23018, 40'h22010, 40'h21008};
    pc = {40'h33018, 40'h32010, 40'h31008};
    // tree A
    mem[40'h11008] = ent(40'h12000, 0);
    mem[40'h12010] = ent(40'h13000, 0);
    mem[40'h13018] = ent(40'h14000, 0);
    mem[40'h14050] = ent(40'h15000, 12'h001);
    mem[40'h14058] = ~(64'h1 << 7);
    mem[40'h14060] = ent(0, 12'h001); mem[40'h14068] = '1;
    mem[40'h14070] = ent(0, 12'h002); mem[40'h14078] = '0;
    mem[40'h14080] = ent(0, 12'h01A); mem[40'h14088] = '1;
    mem[40'h14090] = ent(0, 12'h00A); mem[40'h14098] = '0;
    mem[40'h140A0] = ent(0, 12'h000); mem[40'h140A8] = ~64'h1;
    // tree B: full collapse
    mem[40'h21008] = ent(40'h22000, 0);
    mem[40'h22010] = ent(40'h23000, 0);
    mem[40'h23018] = ent(40'h24000, 0);
    mem[40'h24000] = ent(40'h25000, 0);
    mem[40'h24008] = ~(64'h1 << 63);
    // tree C: stops on live pointer at level 3
    mem[40'h31008] = ent(40'h32000, 0);
    mem[40'h32010] = ent(40'h33000, 0);
    mem[40'h33018] = ent(40'h34000, 0);
    mem[40'h33100] = ent(40'h39000, 0);
    mem[40'h34000] = ent(40'h35000, 0);
    mem[40'h34008] = ~64'h1;

    repeat (4) @(negedge clk);
    chk(busy == 1'b0 && mem_req_valid == 1'b0 && free_valid == 1'b0, "R1 reset outputs idle",
        {61'b0, busy, mem_req_valid, free_valid}, 64'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(wb_ready == 1'b1 && busy == 1'b0, "R9 ready after reset", {62'b0, wb_ready, busy}, 64'h2);

    do_wb(MIXED, 2'd0, 9, 40'h14050, pa);
    chk(mrd(40'h14058)[9] == 1'b0, "R3 non-uniform clears bit", mrd(40'h14058), ~(64'h1 << 7 | 64'h1 << 9));
    do_wb(ONES, 2'd0, 9, 40'h14050, pa);
    chk(mrd(40'h14058) == ~(64'h1 << 7), "R4 vector word at entry+8", mrd(40'h14058), ~(64'h1 << 7));
    do_wb(ZEROS, 2'd0, 7, 40'h14050, pa);
    chk(mrd(40'h14058)[7] == 1'b0, "R3 uniform but differing tag", mrd(40'h14058), ~(64'h1 << 7));
    do_wb(ONES, 2'd0, 7, 40'h14050, pa);
    chk(mrd(40'h14050) == 64'h1, "R5 leaf pointer nulled", mrd(40'h14050), 64'h1);
    chk(mrd(40'h13018) == ent(40'h14000, 0), "R8 scan aborted on differing tag",
        mrd(40'h13018), ent(40'h14000, 0));
    do_wb(ONES, 2'd0, 7, 40'h14050, pa);
    chk(mrd(40'h14058) == '1, "R6 bit already set", mrd(40'h14058), '1);
    do_wb(ONES, 2'd3, 2, 40'h14060, pa);
    chk(mrd(40'h14068) == ~(64'h1 << 2), "R3 unsupported width code", mrd(40'h14068), ~(64'h1 << 2));
    do_wb(PAT2, 2'd1, 4, 40'h14070, pa);
    chk(mrd(40'h14078) == (64'h1 << 4), "R2 2-bit tags match", mrd(40'h14078), 64'h1 << 4);
    do_wb(PAT4, 2'd2, 5, 40'h14080, pa);
    chk(mrd(40'h14088) == ~(64'h1 << 5), "R3 high tag-field bits differ", mrd(40'h14088), ~(64'h1 << 5));
    do_wb(PAT4, 2'd2, 63, 40'h14090, pa);
    chk(mrd(40'h14098) == (64'h1 << 63), "R2 4-bit tags match", mrd(40'h14098), 64'h1 << 63);
    do_wb(ZEROS, 2'd0, 0, 40'h140A0, pa);
    chk(mrd(40'h140A8) == '1 && mrd(40'h140A0) == 64'h0, "R6 null pointer no contraction",
        mrd(40'h140A8), '1);

    do_wb(ZEROS, 2'd2, 63, 40'h24000, pb);
    chk(mrd(40'h23018) == 64'h0, "R7 level-3 parent nulled", mrd(40'h23018), 64'h0);
    chk(mrd(40'h21008) == 64'h0, "R7 level-1 parent nulled", mrd(40'h21008), 64'h0);

    do_wb(ZEROS, 2'd1, 0, 40'h34000, pc);
    chk(mrd(40'h33018) == 64'h0, "R7 level-4 subtable collapsed", mrd(40'h33018), 64'h0);
    chk(mrd(40'h32010) == ent(40'h33000, 0), "R8 scan aborted on live pointer",
        mrd(40'h32010), ent(40'h33000, 0));

    summary();
    $finish;
  end
endmodule